// File: doc/BRIEF.md
# Gated Duty-Cycle Measurement Timer

This block measures the duty cycle of a pulse-width-modulated sensor output. The system clock is divided by a fixed prescale factor into a tick. Every timed element in the block moves on that tick. A high-time counter accumulates ticks while the synchronised sensor level is high and software has enabled the run. A separate 16-bit reload timer acts as a shared time base, and an overflow extension counter widens it.

Each overflow of the reload timer does two jobs. It emits a one-clock baud-rate tick for a neighbouring serial unit, and it advances the extension counter. On every falling edge of the sensor input, the block takes a time stamp from the extension counter and the live timer value. It turns the distance to the previous stamp into a period measured in ticks. The block then presents the accumulated high time and that period with a one-cycle valid strobe. Dividing high time by period gives the duty cycle.

Top module: `duty_meter`

## Requirements
- R1: The prescaler produces one tick every PRESCALE clock cycles (default 12). All counters, the synchroniser and the time base change state only on a tick.
- R2: The high-time counter advances by one on a tick only when the synchronised sensor level is 1 and `run_en` is 1. A pulse driven while `run_en` is 0 reports a high time of 0.
- R3: A falling edge of the sensor level, seen after a two-stage synchroniser, triggers a capture. Every capture after the first raises `res_valid` for exactly one clock. The first falling edge after reset only records a reference and produces no `res_valid`.
- R4: The time-base timer reloads with 65536 minus `reload_div` on each overflow, so it overflows once every `reload_div` ticks (0 means 65536). Each overflow produces a one-clock `baud_tick` pulse, which gives a spacing of `reload_div`×PRESCALE clocks.
- R5: `period` equals the number of ticks between the current falling edge and the previous one. It is computed from the captured extension-counter and timer values and stays correct when the 8-bit extension counter wraps, as long as the true period is below 256×`reload_div` ticks.
- R6: The high-time counter returns to 0 after every capture, so each `hi_time` covers only the high phase that ends at that falling edge.
- R7: The 12-bit high-time counter saturates at 4095. A high phase that asks for a 4096th count reports `hi_time` = 4095 with `ovf_err` = 1. A high phase of exactly 4095 ticks reports `ovf_err` = 0. The flag clears for the following result.
- R8: After reset, `res_valid`, `baud_tick`, `ovf_err`, `hi_time` and `period` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sens_in | input | 1 | PWM sensor output (asynchronous) |
| run_en | input | 1 | Software run enable for the high-time counter |
| reload_div | input | 16 | Ticks between time-base overflows |
| res_valid | output | 1 | One-clock strobe marking a new result |
| hi_time | output | 12 | Captured high time in ticks |
| period | output | 24 | Captured period in ticks |
| ovf_err | output | 1 | High-time counter saturated during this result |
| baud_tick | output | 1 | One-clock pulse per time-base overflow |

## Verification
On every cycle, the assertions check the following: the tick spacing, the reload value loaded after an overflow, the single-clock width of `baud_tick` and `res_valid`, that the high-time counter holds when its gate is closed, that it clears after a capture, and that the saturation flag stays set until it is consumed. Only the bench scenarios can show that the reported numbers are correct. These cover exact high times under enabled and disabled runs, periods that span an extension-counter wrap, suppression of the first result, the 4095/4096 saturation boundary, and `baud_tick` spacing in clocks.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int TIMER_W = 16;
  localparam int EXT_W   = 8;
  localparam int HIGH_W  = 12;
  localparam int PER_W   = TIMER_W + EXT_W;

  typedef logic [TIMER_W-1:0] timer_t;
  typedef logic [EXT_W-1:0]   ext_t;
  typedef logic [HIGH_W-1:0]  high_t;
  typedef logic [PER_W-1:0]   per_t;

  localparam high_t HIGH_MAX = '1;

  // Ticks between two stamps: each extension step is worth div ticks.
  function automatic per_t period_ticks(ext_t ext_now, timer_t t_now,
                                        ext_t ext_ref, timer_t t_ref,
                                        timer_t div);
    ext_t dext;
    per_t span;
    dext = ext_now - ext_ref;
    span = (div == '0) ? per_t'(1 << TIMER_W) : per_t'(div);
    return per_t'(dext) * span + per_t'(t_now) - per_t'(t_ref);
  endfunction

  function automatic timer_t reload_of(timer_t div);
    return timer_t'(0) - div;
  endfunction
endpackage

// File: rtl/dcm_prescaler.sv
module dcm_prescaler #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      logic [CW-1:0] cnt;
      assign tick = (cnt == CW'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
      end
      // R1: ticks never arrive on adjacent clocks
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dcm_timebase.sv
module dcm_timebase
  import dcm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  timer_t reload_div,
  output timer_t timer,
  output ext_t   ext,
  output logic   ovf_evt,
  output logic   baud_tick
);
  timer_t reload_val;
  assign reload_val = reload_of(reload_div);
  assign ovf_evt    = tick && (timer == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer     <= '1;
      ext       <= '0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= ovf_evt;
      if (ovf_evt) begin
        timer <= reload_val;
        ext   <= ext + 1'b1;
      end else if (tick) begin
        timer <= timer + 1'b1;
      end
    end
  end

  // R4: an overflow loads the programmed reload value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (timer == $past(reload_val)));
  // R4: baud pulse lasts one clock
  a_r4_baud_single: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
  // R1: time base frozen between ticks
  a_r1_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(timer));
endmodule

// File: rtl/dcm_high_ctr.sv
module dcm_high_ctr
  import dcm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  sens_in,
  input  logic  run_en,
  output logic  fall_evt,
  output high_t hi_cnt,
  output logic  sat
);
  logic [1:0] sync_q;
  logic       level_d;
  logic       level;
  logic       gate_open;

  assign level     = sync_q[1];
  assign fall_evt  = tick && level_d && !level;
  assign gate_open = level && run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      level_d <= 1'b0;
    end else if (tick) begin
      sync_q  <= {sync_q[0], sens_in};
      level_d <= level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      sat    <= 1'b0;
    end else if (fall_evt) begin
      hi_cnt <= '0;
      sat    <= 1'b0;
    end else if (tick && gate_open) begin
      if (hi_cnt == HIGH_MAX) sat    <= 1'b1;
      else                    hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2: closed gate leaves the count untouched
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && !(tick && gate_open)) |=> $stable(hi_cnt));
  // R6: count restarts from zero after a capture
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (hi_cnt == '0 && !sat));
  // R7: saturation flag persists until consumed
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !fall_evt) |=> (sat && hi_cnt == HIGH_MAX));
endmodule

// File: rtl/duty_meter.sv
module duty_meter
  import dcm_pkg::*;
#(
  parameter int PRESCALE = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sens_in,
  input  logic                 run_en,
  input  logic [TIMER_W-1:0]   reload_div,
  output logic                 res_valid,
  output logic [HIGH_W-1:0]    hi_time,
  output logic [PER_W-1:0]     period,
  output logic                 ovf_err,
  output logic                 baud_tick
);
  logic   tick;
  timer_t timer;
  ext_t   ext;
  logic   ovf_evt;
  logic   fall_evt;
  high_t  hi_cnt;
  logic   sat;

  timer_t ref_timer;
  ext_t   ref_ext;
  logic   have_ref;

  dcm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  dcm_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload_div(reload_div),
    .timer(timer), .ext(ext), .ovf_evt(ovf_evt), .baud_tick(baud_tick)
  );

  dcm_high_ctr u_hi (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sens_in(sens_in),
    .run_en(run_en), .fall_evt(fall_evt), .hi_cnt(hi_cnt), .sat(sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      hi_time   <= '0;
      period    <= '0;
      ovf_err   <= 1'b0;
      ref_timer <= '0;
      ref_ext   <= '0;
      have_ref  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (fall_evt) begin
        ref_timer <= timer;
        ref_ext   <= ext;
        have_ref  <= 1'b1;
        if (have_ref) begin
          res_valid <= 1'b1;
          hi_time   <= hi_cnt;
          ovf_err   <= sat;
          period    <= period_ticks(ext, timer, ref_ext, ref_timer, reload_div);
        end
      end
    end
  end

  // R3: result strobe is a single clock wide
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R3: no result without a prior reference edge
  a_r3_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(have_ref));
  // R4: the baud pulse follows each overflow
  a_r4_baud_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> baud_tick);
endmodule

// File: tb/duty_meter_tb.sv
module duty_meter_tb;
  localparam int PRE  = 12;
  localparam int DIV  = 20;
  localparam int HMAX = 4095;

  typedef struct {
    int hi;
    int per;
    bit err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sens_in = 1'b0;
  logic        run_en = 1'b0;
  logic [15:0] reload_div = 16'(DIV);
  logic        res_valid;
  logic [11:0] hi_time;
  logic [23:0] period;
  logic        ovf_err;
  logic        baud_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit have_ref = 1'b0;
  int prev_low = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  duty_meter u_dut (
    .clk(clk), .rst_n(rst_n), .sens_in(sens_in), .run_en(run_en),
    .reload_div(reload_div), .res_valid(res_valid), .hi_time(hi_time),
    .period(period), .ovf_err(ovf_err), .baud_tick(baud_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one high phase of h ticks then a low phase of l ticks (l >= 4)
  task automatic send_pulse(input int h, input int l, input bit run);
    exp_t e;
    run_en  = run;
    sens_in = 1'b1;
    repeat (h * PRE) @(negedge clk);
    sens_in = 1'b0;
    if (have_ref) begin
      e.hi  = run ? ((h > HMAX) ? HMAX : h) : 0;
      e.per = prev_low + h;
      e.err = run && (h > HMAX);
      q.push_back(e);
    end
    have_ref = 1'b1;
    prev_low = l;
    repeat (l * PRE) @(negedge clk);
  endtask

  // Monitor: compare each result against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(int'(hi_time) == e.hi, "R2 R6 hi_time", int'(hi_time), e.hi);
          chk(int'(period) == e.per, "R5 period", int'(period), e.per);
          chk(ovf_err == e.err, "R7 ovf_err", int'(ovf_err), int'(e.err));
        end
      end
    end
  end

  // Monitor: baud tick spacing (R1, R4)
  initial begin
    int last;
    int cyc;
    last = -1;
    cyc  = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && baud_tick) begin
        if (last >= 0) chk(cyc - last == DIV * PRE, "R1 R4 baud spacing", cyc - last, DIV * PRE);
        last = cyc;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R8: reset state
    chk(res_valid == 1'b0, "R8 res_valid", int'(res_valid), 0);
    chk(hi_time == '0, "R8 hi_time", int'(hi_time), 0);
    chk(period == '0, "R8 period", int'(period), 0);
    chk(ovf_err == 1'b0, "R8 ovf_err", int'(ovf_err), 0);
    repeat (10 * PRE) @(negedge clk);

    send_pulse(5, 10, 1'b1);     // R3: reference only, no result
    send_pulse(3, 7, 1'b1);
    send_pulse(8, 4, 1'b0);      // R2: disabled run
    send_pulse(1, 4, 1'b1);
    send_pulse(37, 50, 1'b1);
    send_pulse(4095, 20, 1'b1);  // R7: boundary, no error
    send_pulse(4100, 6, 1'b1);   // R7: saturation, extension wrap for R5
    send_pulse(6, 6, 1'b1);      // R7: flag cleared, R6 fresh count
    send_pulse(200, 9, 1'b1);
    send_pulse(2, 5, 1'b1);
    repeat (6 * PRE) @(negedge clk);

    chk(q.size() == 0, "R3 results outstanding", q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule